// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Majority Vote

This block receives asynchronous serial frames on a single idle-high line without any forwarded clock. The line is first brought into the local clock domain through a two-stage flip-flop synchroniser. A falling edge seen while idle marks a start bit and realigns the local sample phase, after which the line is sampled a fixed number of times per bit (OVS samples, one every DIV clock cycles). Each bit value is decided by a two-out-of-three majority over the three samples nearest the bit centre, which rejects short glitches and jitter near bit boundaries.

A frame is one low start bit, DATA_W data bits sent least significant bit first, one parity bit and one high stop bit. After the stop bit the receiver checks parity and framing. A good frame presents the word with a one-cycle valid strobe and a one-cycle ack pulse for the return channel; a bad frame produces a one-cycle nack pulse together with the flag naming the fault, and the word is discarded.

Top module: `ovs_frame_rx`

## Requirements
- R1: After reset, data_valid_o, ack_o, nack_o, parity_err_o and frame_err_o are all low, and they stay low while the line idles high.
- R2: A frame of start bit 0, DATA_W data bits least significant bit first, a parity bit and stop bit 1 whose parity is correct yields exactly one cycle of data_valid_o with data_o equal to the word, and one single-cycle ack_o in that same cycle.
- R3: With the default five samples per bit, only samples 2, 3 and 4 of a bit vote and the bit takes the value held by at least two of them; a disturbance on samples 1 and 5, or on any one centre sample, leaves the bit unchanged. With three samples per bit all three vote.
- R4: A low pulse on the line whose start bit no longer votes low at its centre is treated as a glitch: the receiver returns to idle and produces no data_valid_o, ack_o or nack_o.
- R5: Parity is even by default (ODD_PARITY = 0: data bits plus parity bit hold an even number of ones). A mismatch raises parity_err_o for one cycle with nack_o and without data_valid_o.
- R6: A stop bit that votes low raises frame_err_o for one cycle with nack_o and without data_valid_o; parity and framing faults in the same frame raise both flags.
- R7: Every frame whose start bit is accepted is answered by exactly one single-cycle pulse of either ack_o or nack_o, never both.
- R8: The sample phase is realigned on every start edge, so frames sent back to back with no idle time after the stop bit are all received correctly.
- R9: data_valid_o, ack_o, nack_o, parity_err_o and frame_err_o are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | DATA_W | Received word, meaningful while data_valid_o is high |
| data_valid_o | output | 1 | One-cycle strobe for a good word |
| ack_o | output | 1 | One-cycle acknowledge for a good frame |
| nack_o | output | 1 | One-cycle negative acknowledge for a bad frame |
| parity_err_o | output | 1 | One-cycle flag: parity mismatch |
| frame_err_o | output | 1 | One-cycle flag: stop bit voted low |

## Verification
On every cycle the assertions hold the answer rules: ack and nack never coincide, a valid word always carries an ack, each error flag comes with a nack and every nack has a cause, strobes last one cycle, a rejected start glitch is followed by silence, and the vote tally starts clean at the first sample of each bit. Whether the vote picks the right samples, whether the word is assembled in the right bit order and whether parity is computed correctly can only be shown by the bench's frames, which inject noise on chosen samples, corrupt parity and stop bits, send short start glitches and stream frames back to back.

// File: rtl/orx_pkg.sv
package orx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // A sample index (1-based) takes part in the vote when it is one of the
  // three closest to the bit centre.
  function automatic logic vote_tap(input int idx, input int ovs);
    int mid;
    mid = (ovs + 1) / 2;
    return (idx >= mid - 1) && (idx <= mid + 1);
  endfunction

  // Two or more of three voting samples high decide a one.
  function automatic logic majority3(input logic [1:0] ones);
    return ones >= 2'd2;
  endfunction

  // Non-zero when the received parity bit disagrees with the data.
  function automatic logic parity_mismatch(input logic data_xor, input logic par_bit,
                                           input logic odd_mode);
    return data_xor ^ par_bit ^ odd_mode;
  endfunction

endpackage

// File: rtl/orx_sync.sv
module orx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/orx_sampler.sv
module orx_sampler
  import orx_pkg::*;
#(
  parameter int OVS = 5,
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic realign,
  input  logic active,
  output logic bit_done,
  output logic bit_val
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IW = $clog2(OVS + 1);

  logic [DW-1:0] div_cnt;
  logic [IW-1:0] idx;
  logic [1:0]    ones;
  logic          strobe, tap, hit;
  logic [1:0]    ones_next;

  assign strobe    = (div_cnt == DW'(DIV - 1));
  assign tap       = vote_tap(int'(idx), OVS);
  assign hit       = tap & line_s;
  assign ones_next = ones + {1'b0, hit};
  assign bit_done  = active & strobe & (idx == IW'(OVS));
  assign bit_val   = majority3(ones_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      idx     <= IW'(1);
      ones    <= '0;
    end else if (realign) begin
      // the edge cycle itself counts as the first divider tick
      div_cnt <= DW'(1);
      idx     <= IW'(1);
      ones    <= '0;
    end else if (active && strobe) begin
      div_cnt <= '0;
      if (idx == IW'(OVS)) begin
        idx  <= IW'(1);
        ones <= '0;
      end else begin
        idx  <= idx + IW'(1);
        ones <= ones_next;
      end
    end else if (active) begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  assert_tally_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe && idx == IW'(1)) |-> (ones == 2'd0));

  assert_realign_no_decision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !bit_done);

  initial begin
    assert (OVS >= 3 && (OVS % 2) == 1) else $error("OVS must be odd and at least 3");
    assert (DIV >= 2) else $error("DIV must be at least 2");
  end
endmodule

// File: rtl/orx_framer.sv
module orx_framer
  import orx_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter logic ODD_PARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              bit_done,
  input  logic              bit_val,
  output logic              realign,
  output logic              active,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t         state;
  logic              line_prev;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     bit_cnt;
  logic              par_bit;
  logic              fall, glitch_evt, frame_end, par_bad, stop_bad;

  assign fall       = line_prev & ~line_s;
  assign realign    = (state == ST_IDLE) & fall;
  assign active     = (state != ST_IDLE);
  assign glitch_evt = bit_done & (state == ST_START) & bit_val;
  assign frame_end  = bit_done & (state == ST_STOP);
  assign par_bad    = parity_mismatch(^shreg, par_bit, ODD_PARITY);
  assign stop_bad   = ~bit_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      line_prev    <= 1'b1;
      shreg        <= '0;
      bit_cnt      <= '0;
      par_bit      <= 1'b0;
      data_o       <= '0;
      data_valid_o <= 1'b0;
      ack_o        <= 1'b0;
      nack_o       <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      line_prev    <= line_s;
      data_valid_o <= 1'b0;
      ack_o        <= 1'b0;
      nack_o       <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
      case (state)
        ST_IDLE:  if (fall) state <= ST_START;
        ST_START: if (bit_done) begin
          bit_cnt <= '0;
          state   <= bit_val ? ST_IDLE : ST_DATA;
        end
        ST_DATA:  if (bit_done) begin
          shreg   <= {bit_val, shreg[DATA_W-1:1]};
          bit_cnt <= bit_cnt + CW'(1);
          if (bit_cnt == CW'(DATA_W - 1)) state <= ST_PAR;
        end
        ST_PAR:   if (bit_done) begin
          par_bit <= bit_val;
          state   <= ST_STOP;
        end
        ST_STOP:  if (bit_done) begin
          state <= ST_IDLE;
          if (par_bad || stop_bad) begin
            nack_o       <= 1'b1;
            parity_err_o <= par_bad;
            frame_err_o  <= stop_bad;
          end else begin
            data_o       <= shreg;
            data_valid_o <= 1'b1;
            ack_o        <= 1'b1;
          end
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_ack_nack_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));
  assert_frame_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (ack_o || nack_o));
  assert_valid_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> ack_o);
  assert_parity_flag_nacks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_o |-> (nack_o && !data_valid_o));
  assert_frame_flag_nacks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> (nack_o && !data_valid_o));
  assert_nack_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> (parity_err_o || frame_err_o));
  assert_glitch_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_evt |=> !(data_valid_o || ack_o || nack_o));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_o || ack_o || nack_o) |=> !(data_valid_o || ack_o || nack_o));
endmodule

// File: rtl/ovs_frame_rx.sv
module ovs_frame_rx #(
  parameter int   OVS        = 5,
  parameter int   DIV        = 2,
  parameter int   DATA_W     = 8,
  parameter logic ODD_PARITY = 1'b0,
  parameter int   SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  logic line_s, realign, active, bit_done, bit_val;

  orx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rx_i), .sync_o(line_s)
  );

  orx_sampler #(.OVS(OVS), .DIV(DIV)) u_samp (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .realign(realign),
    .active(active), .bit_done(bit_done), .bit_val(bit_val)
  );

  orx_framer #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_frm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .bit_done(bit_done),
    .bit_val(bit_val), .realign(realign), .active(active),
    .data_o(data_o), .data_valid_o(data_valid_o), .ack_o(ack_o),
    .nack_o(nack_o), .parity_err_o(parity_err_o), .frame_err_o(frame_err_o)
  );
endmodule

// File: tb/sim_ovs_frame_rx.sv
`timescale 1ns/1ps
module sim_ovs_frame_rx;
  localparam int OVS = 5;
  localparam int DIV = 2;
  localparam int P   = OVS * DIV;           // clocks per bit
  // noise flips the line at offsets 0,1,2 and 5 of a data bit:
  // sample 1 (offset 1) and sample 3 (offset 5) are disturbed
  localparam logic [P-1:0] NOISE = 10'b00_0010_0111;

  // {data, bad_parity, stop_low, noisy}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {8'h00, 3'b000}, {8'hFF, 3'b000}, {8'hA5, 3'b000}, {8'h3C, 3'b001},
    {8'h81, 3'b100}, {8'h5A, 3'b010}, {8'h7E, 3'b110}, {8'h01, 3'b001},
    {8'hC3, 3'b101}, {8'h96, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [7:0] data;
  logic dv, ack, nack, perr, ferr;

  int errors = 0;
  int checks = 0;
  int n_dv, n_ack, n_nack, n_perr, n_ferr, n_both, n_long;
  logic [7:0] dq [8];
  logic prev_any;

  always #5 clk = ~clk;

  ovs_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .data_o(data), .data_valid_o(dv),
    .ack_o(ack), .nack_o(nack), .parity_err_o(perr), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (dv) begin
        if (n_dv < 8) dq[n_dv] = data;
        n_dv++;
      end
      if (ack)  n_ack++;
      if (nack) n_nack++;
      if (perr) n_perr++;
      if (ferr) n_ferr++;
      if (ack && nack) n_both++;
      if (prev_any && (dv || ack || nack || perr || ferr)) n_long++;
      prev_any = dv || ack || nack || perr || ferr;
    end
  end

  task automatic clear_counts();
    n_dv = 0; n_ack = 0; n_nack = 0; n_perr = 0; n_ferr = 0; n_both = 0; n_long = 0;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v, input logic [P-1:0] mask);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      rx = v ^ mask[k];
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par,
                            input logic stop_low, input logic noisy);
    logic [P-1:0] m;
    m = noisy ? NOISE : '0;
    send_bit(1'b0, '0);
    for (int i = 0; i < 8; i++) send_bit(d[i], m);
    send_bit((^d) ^ bad_par, m);
    send_bit(~stop_low, '0);
  endtask

  task automatic idle(input int clocks);
    for (int k = 0; k < clocks; k++) begin
      @(negedge clk);
      rx = 1'b1;
    end
  endtask

  initial begin
    prev_any = 1'b0;
    clear_counts();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3 * P);
    // R1: quiet after reset on an idle line
    check({dv, ack, nack, perr, ferr} == 5'b0, "R1 outputs after reset",
          {dv, ack, nack, perr, ferr}, 0);
    check(n_dv + n_ack + n_nack == 0, "R1 no pulses while idle", n_dv + n_ack + n_nack, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic bp, sl, nz, good;
      {d, bp, sl, nz} = VEC[v];
      good = !bp && !sl;
      clear_counts();
      send_frame(d, bp, sl, nz);
      idle(2 * P);
      // R2 / R3: good word delivered, noisy samples outvoted
      check(n_dv == int'(good), nz ? "R3 valid count (noisy)" : "R2 valid count", n_dv, good);
      if (good)
        check(dq[0] == d, nz ? "R3 word under noise" : "R2 word", dq[0], d);
      check(n_ack == int'(good), "R2 ack count", n_ack, good);
      check(n_nack == int'(!good), "R7 nack count", n_nack, !good);
      check(n_perr == int'(bp), "R5 parity flag", n_perr, bp);
      check(n_ferr == int'(sl), "R6 framing flag", n_ferr, sl);
      check(n_both == 0, "R7 ack and nack together", n_both, 0);
      check(n_long == 0, "R9 strobe longer than one cycle", n_long, 0);
    end

    // R4: short low pulse on idle line is a start glitch
    clear_counts();
    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b0;
    idle(4 * P);
    check(n_dv + n_ack + n_nack == 0, "R4 glitch produces nothing", n_dv + n_ack + n_nack, 0);
    clear_counts();
    send_frame(8'h6D, 1'b0, 1'b0, 1'b0);
    idle(2 * P);
    check(n_dv == 1 && dq[0] == 8'h6D, "R4 recovery after glitch", dq[0], 8'h6D);

    // R8: three frames back to back, no idle time between
    clear_counts();
    send_frame(8'h12, 1'b0, 1'b0, 1'b0);
    send_frame(8'hED, 1'b0, 1'b0, 1'b1);
    send_frame(8'h80, 1'b0, 1'b0, 1'b0);
    idle(2 * P);
    check(n_dv == 3, "R8 back-to-back count", n_dv, 3);
    check(dq[0] == 8'h12, "R8 first word", dq[0], 8'h12);
    check(dq[1] == 8'hED, "R8 second word", dq[1], 8'hED);
    check(dq[2] == 8'h80, "R8 third word", dq[2], 8'h80);
    check(n_ack == 3 && n_nack == 0, "R7 back-to-back answers", n_ack, 3);
    check(n_long == 0, "R9 back-to-back strobes", n_long, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule